// File: doc/BRIEF.md
# Multi-Slot I2C Target Address Matcher

This block listens to an already filtered SCL/SDA pair and picks out the first byte after each START or repeated START. It compares the received 7-bit address against four programmable slots. Each slot has an address, a don't-care mask and a general-call enable. When one or more slots match, the block pulls SDA low for the acknowledge clock, sets a sticky flag for every matching slot and reports the lowest matching slot. When wake reporting is enabled, a match also records a wake event, the read/write bit of the frame, and a flag that the acknowledge clock of that frame has completed.

Slots are written through a plain write-enable port that selects one slot at a time. Status flags are cleared through a second write-enable port with write-one-to-clear semantics. The block has no streaming data path. Every pin is a level control or status signal with no handshake, so there is no back-pressure to manage. After the address byte the block stays passive until the next START.

Top module: `i2c_multi_addr_match`

## Requirements
- R1: The block holds four independent slots, each with a 7-bit address, a 7-bit mask and a general-call enable. A cycle with `cfg_we_i` high loads `cfg_addr_i`, `cfg_mask_i` and `cfg_gc_i` into the slot selected by `cfg_sel_i`. After reset every slot is all zero.
- R2: A mask bit of 1 makes the matching received address bit don't-care. A mask bit of 0 requires that bit to equal the slot address.
- R3: A slot whose address is 7'h00 never produces an own-address match, whatever its mask.
- R4: A received address of 7'h00 (general call) matches a slot only when that slot's general-call enable is 1. It never matches through the address/mask compare.
- R5: `sda_pull_o` goes high one clock after the SCL falling edge that ends the eighth bit and drops one clock after the next SCL falling edge. It does this only when some slot matched and `ack_en_i` was 1 at the START of the frame. Otherwise it stays low (NACK).
- R6: Bit i of `match_flags_o` is set two clocks after the eighth SCL rising edge when slot i matches, and stays set. A `stat_we_i` cycle clears each flag whose bit in `stat_wdata_i[3:0]` is 1. A set in the same cycle wins.
- R7: When several slots match one address, all their flags are set, and `match_idx_o` takes the lowest matching index. `match_idx_o` holds its value when no slot matches.
- R8: If `wake_en_i` is 1 when a match is resolved, `wake_flag_o` sets and `wake_rw_o` takes the frame's read/write bit. `ack_done_o` sets one clock after the SCL falling edge that ends the acknowledge clock of that frame.
- R9: Writing 1 to `stat_wdata_i[5]` clears `ack_done_o` and `wake_rw_o` but not `wake_flag_o`. Only `stat_wdata_i[4]` clears `wake_flag_o`.
- R10: Address bits are sampled on SCL rising edges, most significant bit first. The eighth bit is the read/write bit, and the compare uses the seven bits before it.
- R11: A STOP, or `enable_i` low, returns the matcher to idle. It ignores bus activity until the next START. A repeated START restarts address capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Matcher enable |
| scl_i | input | 1 | Filtered SCL level |
| sda_i | input | 1 | Filtered SDA level |
| ack_en_i | input | 1 | Acknowledge a matched address |
| wake_en_i | input | 1 | Record wake events on a match |
| cfg_we_i | input | 1 | Slot write strobe |
| cfg_sel_i | input | 2 | Slot index to write |
| cfg_addr_i | input | 7 | Slot address |
| cfg_mask_i | input | 7 | Slot don't-care mask |
| cfg_gc_i | input | 1 | Slot general-call enable |
| stat_we_i | input | 1 | Status clear strobe |
| stat_wdata_i | input | 6 | Clear bits: [3:0] slot flags, [4] wake, [5] ack-done |
| sda_pull_o | output | 1 | Drive SDA low (acknowledge) |
| match_flags_o | output | 4 | Sticky per-slot match flags |
| match_idx_o | output | 2 | Lowest matching slot of the last match |
| wake_flag_o | output | 1 | Wake event recorded |
| ack_done_o | output | 1 | Acknowledge clock of the wake frame finished |
| wake_rw_o | output | 1 | Read/write bit of the wake frame |

## Verification
On every clock, the embedded properties check several invariants. Match flags only fall after a matching clear write. The acknowledge pull only rises while SCL is low. A general call never hits a slot with its enable off. A zero-address slot without general call never hits. Clearing only ack-done leaves the wake flag set. Mask semantics, the lowest-index choice, MSB-first ordering, and the effect of aborting a frame with STOP, a disable or a repeated START need whole bus frames. Only the bench's scenarios and its cycle model can show those.

// File: rtl/i2c_match_pkg.sv
package i2c_match_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_ACKW = 3'd2,
    PH_ACK  = 3'd3,
    PH_DATA = 3'd4
  } frame_phase_e;
endpackage

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_addr_slot.sv
module i2c_addr_slot #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [ADDR_W-1:0] wr_mask_i,
  input  logic              wr_gc_i,
  input  logic [ADDR_W-1:0] rx_addr_i,
  output logic              hit_o
);
  logic [ADDR_W-1:0] addr_q, mask_q;
  logic              gc_q;
  logic              own_hit, gc_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mask_q <= '0;
      gc_q   <= 1'b0;
    end else if (wr_en_i) begin
      addr_q <= wr_addr_i;
      mask_q <= wr_mask_i;
      gc_q   <= wr_gc_i;
    end
  end

  // own address compare: never for a zero slot or a general-call byte
  assign own_hit = (addr_q != '0) && (rx_addr_i != '0) &&
                   (((rx_addr_i ^ addr_q) & ~mask_q) == '0);
  assign gc_hit  = gc_q && (rx_addr_i == '0);
  assign hit_o   = own_hit | gc_hit;

  // R4
  gc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_addr_i == '0 && !gc_q) |-> !hit_o);
  // R3
  zero_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q == '0 && !gc_q) |-> !hit_o);
endmodule

// File: rtl/i2c_addr_frame.sv
module i2c_addr_frame
  import i2c_match_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              ack_en_i,
  input  logic              any_hit_i,
  output logic [ADDR_W-1:0] rx_addr_o,
  output logic              rx_rw_o,
  output logic              cmp_o,
  output logic              ack_drive_o,
  output logic              ack_end_o
);
  localparam int CNT_W = $clog2(ADDR_W + 1);

  frame_phase_e      phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] shift_q;
  logic              rw_q, cmp_q, ack_lat_q, acked_q, drive_q, end_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      shift_q   <= '0;
      rw_q      <= 1'b0;
      cmp_q     <= 1'b0;
      ack_lat_q <= 1'b0;
      acked_q   <= 1'b0;
      drive_q   <= 1'b0;
      end_q     <= 1'b0;
    end else begin
      cmp_q <= 1'b0;
      end_q <= 1'b0;
      if (cmp_q) acked_q <= any_hit_i & ack_lat_q;
      if (!enable_i || stop_i) begin
        phase_q <= PH_IDLE;
        drive_q <= 1'b0;
      end else if (start_i) begin
        phase_q   <= PH_ADDR;
        cnt_q     <= '0;
        ack_lat_q <= ack_en_i;
        drive_q   <= 1'b0;
      end else begin
        unique case (phase_q)
          PH_ADDR: if (scl_rise_i) begin
            if (cnt_q == CNT_W'(ADDR_W)) begin
              rw_q    <= sda_i;
              cmp_q   <= 1'b1;
              phase_q <= PH_ACKW;
            end else begin
              shift_q <= {shift_q[ADDR_W-2:0], sda_i};
              cnt_q   <= cnt_q + 1'b1;
            end
          end
          PH_ACKW: if (scl_fall_i) begin
            drive_q <= acked_q;
            phase_q <= PH_ACK;
          end
          PH_ACK: if (scl_fall_i) begin
            drive_q <= 1'b0;
            end_q   <= 1'b1;
            phase_q <= PH_DATA;
          end
          default: ;
        endcase
      end
    end
  end

  assign rx_addr_o   = shift_q;
  assign rx_rw_o     = rw_q;
  assign cmp_o       = cmp_q;
  assign ack_drive_o = drive_q;
  assign ack_end_o   = end_q;
endmodule

// File: rtl/i2c_multi_addr_match.sv
module i2c_multi_addr_match #(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 7,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int STAT_W   = NUM_SLOTS + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable_i,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic                 ack_en_i,
  input  logic                 wake_en_i,
  input  logic                 cfg_we_i,
  input  logic [IDX_W-1:0]     cfg_sel_i,
  input  logic [ADDR_W-1:0]    cfg_addr_i,
  input  logic [ADDR_W-1:0]    cfg_mask_i,
  input  logic                 cfg_gc_i,
  input  logic                 stat_we_i,
  input  logic [STAT_W-1:0]    stat_wdata_i,
  output logic                 sda_pull_o,
  output logic [NUM_SLOTS-1:0] match_flags_o,
  output logic [IDX_W-1:0]     match_idx_o,
  output logic                 wake_flag_o,
  output logic                 ack_done_o,
  output logic                 wake_rw_o
);
  localparam int WAKE_BIT = NUM_SLOTS;
  localparam int DONE_BIT = NUM_SLOTS + 1;

  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic [ADDR_W-1:0]    rx_addr;
  logic                 rx_rw, cmp, ack_end;
  logic [NUM_SLOTS-1:0] hit;
  logic [IDX_W-1:0]     low_idx;
  logic                 wake_frame_q;

  i2c_bus_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    i2c_addr_slot #(.ADDR_W(ADDR_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(cfg_we_i && (cfg_sel_i == IDX_W'(g))),
      .wr_addr_i(cfg_addr_i), .wr_mask_i(cfg_mask_i), .wr_gc_i(cfg_gc_i),
      .rx_addr_i(rx_addr), .hit_o(hit[g])
    );
  end

  i2c_addr_frame #(.ADDR_W(ADDR_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .sda_i(sda_i),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_ev), .stop_i(stop_ev), .ack_en_i(ack_en_i),
    .any_hit_i(|hit), .rx_addr_o(rx_addr), .rx_rw_o(rx_rw),
    .cmp_o(cmp), .ack_drive_o(sda_pull_o), .ack_end_o(ack_end)
  );

  always_comb begin
    low_idx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--)
      if (hit[i]) low_idx = IDX_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_flags_o <= '0;
      match_idx_o   <= '0;
      wake_flag_o   <= 1'b0;
      ack_done_o    <= 1'b0;
      wake_rw_o     <= 1'b0;
      wake_frame_q  <= 1'b0;
    end else begin
      if (stat_we_i) begin
        match_flags_o <= match_flags_o & ~stat_wdata_i[NUM_SLOTS-1:0];
        if (stat_wdata_i[WAKE_BIT]) wake_flag_o <= 1'b0;
        if (stat_wdata_i[DONE_BIT]) begin
          ack_done_o <= 1'b0;
          wake_rw_o  <= 1'b0;
        end
      end
      if (ack_end) begin
        if (wake_frame_q) ack_done_o <= 1'b1;
        wake_frame_q <= 1'b0;
      end
      if (cmp) begin
        wake_frame_q <= wake_en_i && (|hit);
        if (|hit) begin
          match_flags_o <= (stat_we_i ? (match_flags_o & ~stat_wdata_i[NUM_SLOTS-1:0])
                                      : match_flags_o) | hit;
          match_idx_o   <= low_idx;
          if (wake_en_i) begin
            wake_flag_o <= 1'b1;
            wake_rw_o   <= rx_rw;
          end
        end
      end
    end
  end

  for (genvar f = 0; f < NUM_SLOTS; f++) begin : g_flag_chk
    // R6
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(match_flags_o[f]) |-> $past(stat_we_i && stat_wdata_i[f]));
  end
  // R5
  pull_on_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_i);
  // R9
  wake_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we_i && stat_wdata_i[DONE_BIT] && !stat_wdata_i[WAKE_BIT] && wake_flag_o) |=> wake_flag_o);
  // R9
  done_clears_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_done_o) |-> !wake_rw_o);
endmodule

// File: tb/i2c_multi_addr_match_tb.sv
module i2c_multi_addr_match_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, scl = 1'b1, sda = 1'b1, ack_en = 1'b0, wake_en = 1'b0;
  logic cfg_we = 1'b0, cfg_gc = 1'b0, stat_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [6:0] cfg_addr = '0, cfg_mask = '0;
  logic [5:0] stat_wdata = '0;
  logic sda_pull, wake_flag, ack_done, wake_rw;
  logic [3:0] flags;
  logic [1:0] idx;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  i2c_multi_addr_match dut_i (
    .clk(clk), .rst_n(rst_n), .enable_i(enable), .scl_i(scl), .sda_i(sda),
    .ack_en_i(ack_en), .wake_en_i(wake_en), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_addr_i(cfg_addr), .cfg_mask_i(cfg_mask), .cfg_gc_i(cfg_gc),
    .stat_we_i(stat_we), .stat_wdata_i(stat_wdata), .sda_pull_o(sda_pull),
    .match_flags_o(flags), .match_idx_o(idx), .wake_flag_o(wake_flag),
    .ack_done_o(ack_done), .wake_rw_o(wake_rw)
  );

  // behavioural reference model, advanced on each rising edge
  int m_a[4], m_m[4], m_g[4];
  int pscl = 1, psda = 1, ph = 0, cnt = 0, rxa = 0, rwb = 0;
  int cmp_p = 0, aend_p = 0, ackl = 0, acked = 0, e_pull = 0;
  int e_flags = 0, e_idx = 0, e_wake = 0, e_done = 0, e_rw = 0, wf = 0;

  function automatic int hits_of(int rx);
    int h = 0;
    for (int s = 0; s < 4; s++) begin
      if (m_g[s] != 0 && rx == 0) h |= (1 << s);
      if (m_a[s] != 0 && rx != 0 && (((rx ^ m_a[s]) & ~m_m[s] & 127) == 0)) h |= (1 << s);
    end
    return h;
  endfunction

  function automatic int lowest(int h);
    for (int s = 0; s < 4; s++) if (h[s]) return s;
    return 0;
  endfunction

  always @(posedge clk) begin : model
    int rise, fall, st, sp, h, oc;
    if (!rst_n) begin
      for (int s = 0; s < 4; s++) begin m_a[s] = 0; m_m[s] = 0; m_g[s] = 0; end
      pscl = 1; psda = 1; ph = 0; cnt = 0; rxa = 0; rwb = 0; cmp_p = 0; aend_p = 0;
      ackl = 0; acked = 0; e_pull = 0; e_flags = 0; e_idx = 0; e_wake = 0;
      e_done = 0; e_rw = 0; wf = 0;
    end else begin
      rise = (scl && !pscl); fall = (!scl && pscl);
      st = (scl && pscl && psda && !sda); sp = (scl && pscl && !psda && sda);
      h = hits_of(rxa);
      if (stat_we) begin
        e_flags &= ~int'(stat_wdata[3:0]);
        if (stat_wdata[4]) e_wake = 0;
        if (stat_wdata[5]) begin e_done = 0; e_rw = 0; end
      end
      if (aend_p) begin if (wf) e_done = 1; wf = 0; end
      if (cmp_p) begin
        wf = (wake_en && h != 0);
        if (h != 0) begin
          e_flags |= h; e_idx = lowest(h);
          if (wake_en) begin e_wake = 1; e_rw = rwb; end
        end
      end
      oc = cmp_p; cmp_p = 0; aend_p = 0;
      if (oc) acked = (h != 0) && ackl;
      if (!enable || sp) begin ph = 0; e_pull = 0; end
      else if (st) begin ph = 1; cnt = 0; ackl = ack_en; e_pull = 0; end
      else if (ph == 1 && rise) begin
        if (cnt == 7) begin rwb = sda; cmp_p = 1; ph = 2; end
        else begin rxa = ((rxa << 1) | sda) & 127; cnt++; end
      end else if (ph == 2 && fall) begin e_pull = acked; ph = 3; end
      else if (ph == 3 && fall) begin e_pull = 0; aend_p = 1; ph = 4; end
      if (cfg_we) begin m_a[cfg_sel] = cfg_addr; m_m[cfg_sel] = cfg_mask; m_g[cfg_sel] = cfg_gc; end
      pscl = scl; psda = sda;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    chk(sda_pull == e_pull[0], "R5 ack pull vs model", sda_pull, e_pull);
    chk(flags == e_flags[3:0], "R6 flags vs model", flags, e_flags);
    chk(idx == e_idx[1:0], "R7 index vs model", idx, e_idx);
    chk(wake_flag == e_wake[0], "R8 wake vs model", wake_flag, e_wake);
    chk(ack_done == e_done[0], "R8 ack-done vs model", ack_done, e_done);
    chk(wake_rw == e_rw[0], "R9 wake rw vs model", wake_rw, e_rw);
  end

  task automatic wcyc(input int n); repeat (n) @(negedge clk); endtask

  task automatic cfg(input int s, input int a, input int m, input bit g);
    @(negedge clk); cfg_we = 1; cfg_sel = 2'(s); cfg_addr = 7'(a); cfg_mask = 7'(m); cfg_gc = g;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic clr(input int bits);
    @(negedge clk); stat_we = 1; stat_wdata = 6'(bits);
    @(negedge clk); stat_we = 0; stat_wdata = '0;
  endtask

  task automatic bus_start; sda = 1; scl = 1; wcyc(4); sda = 0; wcyc(4); scl = 0; wcyc(4); endtask
  task automatic bus_stop; sda = 0; wcyc(4); scl = 1; wcyc(4); sda = 1; wcyc(6); endtask
  task automatic bus_bit(input bit b); sda = b; wcyc(4); scl = 1; wcyc(4); scl = 0; wcyc(4); endtask

  task automatic frame(input int a, input bit rw, input bit exp_ack, input string tag);
    bus_start;
    for (int i = 6; i >= 0; i--) bus_bit(a[i]);
    bus_bit(rw);
    sda = 1; wcyc(4); scl = 1; wcyc(3);
    chk(sda_pull == exp_ack, tag, sda_pull, exp_ack);
    wcyc(1); scl = 0; wcyc(3);
    chk(sda_pull == 1'b0, "R5 release after ninth clock", sda_pull, 0);
    bus_stop;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R11 watchdog act=running exp=done");
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    wcyc(5); rst_n = 1; wcyc(2);
    chk(flags == 0 && idx == 0, "R1 reset flags/index", flags, 0);
    chk(!wake_flag && !ack_done && !wake_rw && !sda_pull, "R8 reset wake state", wake_flag, 0);
    enable = 1; ack_en = 1;
    cfg(0, 'h50, 0, 0); cfg(1, 'h20, 'h0F, 0); cfg(2, 0, 0, 1); cfg(3, 'h50, 0, 0);
    frame('h50, 0, 1, "R7 ack for duplicate slots");
    chk(flags == 4'b1001, "R7 both flags", flags, 4'b1001);
    chk(idx == 0, "R7 lowest index", idx, 0);
    clr('hF);
    frame('h2A, 1, 1, "R10 MSB-first masked ack");
    chk(flags == 4'b0010 && idx == 1, "R2 mask match slot1", flags, 4'b0010);
    frame('h30, 0, 0, "R2 unmasked bit differs nack");
    chk(flags == 4'b0010, "R2 no new flag", flags, 4'b0010);
    frame('h00, 0, 1, "R4 general call ack");
    chk(flags == 4'b0110 && idx == 2, "R4 general call slot2", flags, 4'b0110);
    cfg(2, 0, 'h7F, 0);
    frame('h00, 0, 0, "R4 general call disabled nack");
    frame('h11, 0, 0, "R3 zero slot full mask nack");
    chk(flags == 4'b0110, "R3 no flag from zero slot", flags, 4'b0110);
    ack_en = 0;
    frame('h50, 0, 0, "R5 ack disabled nack");
    chk(flags == 4'b1111, "R6 flags set without ack", flags, 4'b1111);
    clr('h01);
    chk(flags == 4'b1110, "R6 partial clear", flags, 4'b1110);
    frame('h50, 1, 0, "R8 wake disabled nack");
    chk(!wake_flag, "R8 no wake when disabled", wake_flag, 0);
    ack_en = 1; wake_en = 1;
    frame('h2B, 1, 1, "R8 wake frame ack");
    chk(wake_flag && wake_rw && ack_done, "R8 wake captured", {wake_flag, wake_rw, ack_done}, 7);
    clr('h20);
    chk(wake_flag && !wake_rw && !ack_done, "R9 ack-done clear keeps wake", {wake_flag, wake_rw, ack_done}, 4);
    clr('h10);
    chk(!wake_flag, "R9 wake clear", wake_flag, 0);
    wake_en = 0; clr('hF);
    bus_start;
    for (int i = 6; i >= 3; i--) bus_bit(1'((7'h50 >> i) & 1));
    bus_stop;
    for (int i = 2; i >= 0; i--) bus_bit(1'((7'h50 >> i) & 1));
    bus_bit(0); bus_bit(1); wcyc(4);
    chk(flags == 0 && !sda_pull, "R11 stop aborts frame", flags, 0);
    bus_start; bus_bit(1); bus_bit(1);
    scl = 1; wcyc(4);
    frame('h50, 0, 1, "R11 repeated start ack");
    chk(flags == 4'b1001, "R11 repeated start match", flags, 4'b1001);
    clr('hF);
    bus_start; bus_bit(1); bus_bit(0);
    enable = 0; wcyc(4); enable = 1;
    bus_bit(1); bus_bit(0); bus_bit(0); bus_bit(0); bus_bit(0); bus_bit(0);
    sda = 1; wcyc(4); scl = 1; wcyc(4); scl = 0; wcyc(4); bus_stop;
    chk(flags == 0, "R11 disable aborts frame", flags, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule